// File: doc/BRIEF.md
# Serial ADC Readout Master

This block is a synchronous master that fetches a single conversion result from a two-channel, 10-bit serial converter. The link uses SPI mode 0: the serial clock rests low, the master samples the returned data on each rising edge, and the converter updates its data line on each falling edge. A pulse on `start_i` pulls the active-low select line down. The master then produces 16 serial clock cycles, each half-period lasting a parameter-set number of system clocks. It gathers the returned bitstream as two 8-bit bytes, one after the other.

Each frame carries a three-bit marker of ones, then a channel bit, then the 10-bit result with the most significant bit first, then two sub-bits. Once the frame is complete, the master releases the select line and pulses `done_o` for one system clock. In that same cycle it presents the unpacked result, the channel bit, the sub-bits and a flag that reports a damaged marker. These outputs then stay unchanged until the next frame ends.

The divider must keep the serial clock at or below 2.17 MHz for the chosen system clock. Elaboration rejects any parameter set that breaks this limit.

Top module: `adc_rd_master`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sclk_o` is 0, `done_o` is 0, and `sample_o`, `chan_o`, `sub_o` and `frame_err_o` are all zero.
- R2: A `start_i` sampled high while idle drives `cs_n_o` low at the next edge with `sclk_o` still low. The first rising edge of `sclk_o` follows HALF_DIV system clocks later.
- R3: `sclk_o` changes level only every HALF_DIV system clocks while `cs_n_o` is low, and stays low whenever `cs_n_o` is high. Exactly 16 rising edges occur per frame.
- R4: `miso_i` is sampled at each rising edge of `sclk_o`. The first sampled bit is frame bit 15 (the MSB) and the last is frame bit 0.
- R5: The frame unpacks as follows: bits 15..13 are the marker, bit 12 is `chan_o`, bits 11..2 are `sample_o` (bit 11 = D9, bit 2 = D0), and bits 1..0 are `sub_o` (bit 1 = S1, bit 0 = S0).
- R6: `frame_err_o` is 1 when any of frame bits 15..13 is 0, and 0 when all three are 1.
- R7: `cs_n_o` returns high one half-period after the 16th rising edge, with `sclk_o` low at that edge, so that `cs_n_o` is low for 32*HALF_DIV system clocks.
- R8: `done_o` is high for exactly one system clock, in the cycle where `cs_n_o` returns high. The result outputs update only in that cycle and hold their values until the next `done_o`.
- R9: A `start_i` pulse that arrives while a frame is in progress has no effect. The frame keeps its length, only one `done_o` pulse occurs, and no new frame starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to read one frame |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles low |
| done_o | output | 1 | One-cycle pulse when a frame is complete |
| sample_o | output | 10 | Unpacked conversion result |
| chan_o | output | 1 | Channel identification bit |
| sub_o | output | 2 | Sub-bits S1 (bit 1) and S0 (bit 0) |
| frame_err_o | output | 1 | Leading marker missing or damaged |

## Verification
The bound checker watches the serial link on every cycle. It confirms the half-period spacing of every serial clock change, a low clock while select is high, 16 rising edges per frame, and a done pulse that lasts one cycle and coincides with the select release. It also keeps its own copy of the bits sampled on the line and compares the unpacked fields and the error flag against that copy. Only the bench scenarios can show that a start request in mid-frame is ignored, that the first rising edge falls at the correct distance after select, and that the converter model's bit order survives intact across directed and random frames with good and damaged markers.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

   typedef enum logic [0:0] {
      RD_IDLE = 1'b0,
      RD_RUN  = 1'b1
   } rd_state_e;

   function automatic int frame_width(input int lead_w, input int res_w, input int sub_w);
      return lead_w + 1 + res_w + sub_w;
   endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
   parameter int HALF_DIV = 47
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/adc_rx_shift.sv
`timescale 1ns/1ps
module adc_rx_shift #(
   parameter int FRAME_W = 16,
   parameter int BYTE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               shift_i,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o
);
   localparam int N_BYTES = FRAME_W / BYTE_W;

   logic [BYTE_W-1:0] lane_q [N_BYTES];

   for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
      logic lane_in;
      if (g == 0) begin : g_first
         assign lane_in = bit_i;
      end else begin : g_chain
         assign lane_in = lane_q[g-1][BYTE_W-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) begin
            lane_q[g] <= '0;
         end else if (shift_i) begin
            lane_q[g] <= {lane_q[g][BYTE_W-2:0], lane_in};
         end
      end

      assign frame_o[g*BYTE_W +: BYTE_W] = lane_q[g];
   end
endmodule

// File: rtl/adc_frame_unpack.sv
`timescale 1ns/1ps
module adc_frame_unpack #(
   parameter int LEAD_W       = 3,
   parameter int RES_W        = 10,
   parameter int SUB_W        = 2,
   parameter bit CHECK_MARKER = 1'b1,
   localparam int FRAME_W     = LEAD_W + 1 + RES_W + SUB_W
) (
   input  logic [FRAME_W-1:0] frame_i,
   output logic [RES_W-1:0]   sample_o,
   output logic               chan_o,
   output logic [SUB_W-1:0]   sub_o,
   output logic               err_o
);
   logic [LEAD_W-1:0] lead;

   assign lead     = frame_i[FRAME_W-1 -: LEAD_W];
   assign chan_o   = frame_i[RES_W + SUB_W];
   assign sample_o = frame_i[SUB_W +: RES_W];
   assign sub_o    = frame_i[SUB_W-1:0];

   if (CHECK_MARKER) begin : g_marker_chk
      logic [LEAD_W-1:0] miss;
      for (genvar i = 0; i < LEAD_W; i++) begin : g_bit
         assign miss[i] = ~lead[i];
      end
      assign err_o = |miss;
   end else begin : g_marker_off
      logic unused_lead;
      assign unused_lead = ^lead;
      assign err_o = 1'b0;
   end
endmodule

// File: rtl/adc_rd_master.sv
`timescale 1ns/1ps
module adc_rd_master #(
   parameter int SYS_CLK_HZ   = 200_000_000,
   parameter int SCLK_MAX_HZ  = 2_170_000,
   parameter int HALF_DIV     = 47,
   parameter int LEAD_W       = 3,
   parameter int RES_W        = 10,
   parameter int SUB_W        = 2,
   parameter int BYTE_W       = 8,
   parameter bit CHECK_MARKER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             miso_i,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             done_o,
   output logic [RES_W-1:0] sample_o,
   output logic             chan_o,
   output logic [SUB_W-1:0] sub_o,
   output logic             frame_err_o
);
   import adc_rd_pkg::*;

   localparam int FRAME_W = frame_width(LEAD_W, RES_W, SUB_W);
   localparam int N_HALF  = 2 * FRAME_W;
   localparam int PH_W    = $clog2(N_HALF + 1);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_HALF - 1);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if ((SYS_CLK_HZ / (2 * HALF_DIV)) > SCLK_MAX_HZ) begin : g_bad_rate
      $error("serial clock would exceed SCLK_MAX_HZ");
   end
   if ((FRAME_W % BYTE_W) != 0) begin : g_bad_bytes
      $error("frame width must be a whole number of bytes");
   end
   if (LEAD_W < 1 || SUB_W < 1 || RES_W < 1) begin : g_bad_fields
      $error("field widths must be positive");
   end

   rd_state_e         state_q;
   logic [PH_W-1:0]   phase_q;
   logic              sclk_q;
   logic              cs_n_q;
   logic              done_q;
   logic [RES_W-1:0]  sample_q;
   logic              chan_q;
   logic [SUB_W-1:0]  sub_q;
   logic              err_q;

   logic              run;
   logic              tick;
   logic              finish;
   logic              launch;
   logic [FRAME_W-1:0] frame;
   logic [RES_W-1:0]  u_sample;
   logic              u_chan;
   logic [SUB_W-1:0]  u_sub;
   logic              u_err;

   assign run    = (state_q == RD_RUN);
   assign launch = (state_q == RD_IDLE) && start_i;
   assign finish = tick && (phase_q == PH_LAST);

   adc_sclk_gen #(.HALF_DIV(HALF_DIV)) sclk_gen_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   adc_rx_shift #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) rx_shift_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (launch),
      .shift_i (tick && !sclk_q),
      .bit_i   (miso_i),
      .frame_o (frame)
   );

   adc_frame_unpack #(
      .LEAD_W(LEAD_W), .RES_W(RES_W), .SUB_W(SUB_W), .CHECK_MARKER(CHECK_MARKER)
   ) unpack_i (
      .frame_i  (frame),
      .sample_o (u_sample),
      .chan_o   (u_chan),
      .sub_o    (u_sub),
      .err_o    (u_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= RD_IDLE;
         phase_q  <= '0;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
         sample_q <= '0;
         chan_q   <= 1'b0;
         sub_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RD_IDLE: begin
               if (start_i) begin
                  state_q <= RD_RUN;
                  cs_n_q  <= 1'b0;
                  sclk_q  <= 1'b0;
                  phase_q <= '0;
               end
            end
            RD_RUN: begin
               if (finish) begin
                  state_q  <= RD_IDLE;
                  cs_n_q   <= 1'b1;
                  sclk_q   <= 1'b0;
                  done_q   <= 1'b1;
                  sample_q <= u_sample;
                  chan_q   <= u_chan;
                  sub_q    <= u_sub;
                  err_q    <= u_err;
               end else if (tick) begin
                  phase_q <= phase_q + 1'b1;
                  sclk_q  <= ~sclk_q;
               end
            end
            default: state_q <= RD_IDLE;
         endcase
      end
   end

   assign cs_n_o      = cs_n_q;
   assign sclk_o      = sclk_q;
   assign done_o      = done_q;
   assign sample_o    = sample_q;
   assign chan_o      = chan_q;
   assign sub_o       = sub_q;
   assign frame_err_o = err_q;
endmodule

// File: rtl/adc_rd_master_chk.sv
`timescale 1ns/1ps
module adc_rd_master_chk #(
   parameter int HALF_DIV     = 47,
   parameter int LEAD_W       = 3,
   parameter int RES_W        = 10,
   parameter int SUB_W        = 2,
   parameter bit CHECK_MARKER = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             miso_i,
   input logic             cs_n_o,
   input logic             sclk_o,
   input logic             done_o,
   input logic [RES_W-1:0] sample_o,
   input logic             chan_o,
   input logic [SUB_W-1:0] sub_o,
   input logic             frame_err_o
);
   localparam int FRAME_W = LEAD_W + 1 + RES_W + SUB_W;
   localparam int GAP_W   = $clog2(HALF_DIV + 2) + 1;
   localparam int RC_W    = $clog2(FRAME_W + 2) + 1;

   logic               sclk_d;
   logic               cs_d;
   logic [GAP_W-1:0]   gap_q;
   logic [RC_W-1:0]    rises_q;
   logic [FRAME_W-1:0] shadow_q;
   logic               rise_seen;
   logic               any_change;

   assign rise_seen  = sclk_o && !sclk_d;
   assign any_change = (sclk_o != sclk_d) || (cs_n_o != cs_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         cs_d     <= 1'b1;
         gap_q    <= '0;
         rises_q  <= '0;
         shadow_q <= '0;
      end else begin
         sclk_d <= sclk_o;
         cs_d   <= cs_n_o;
         if (any_change) begin
            gap_q <= GAP_W'(1);
         end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
         end
         if (cs_n_o) begin
            rises_q <= '0;
         end else if (rise_seen) begin
            rises_q <= rises_q + 1'b1;
            shadow_q <= {shadow_q[FRAME_W-2:0], miso_i};
         end
      end
   end

   // R3
   idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);

   // R3
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o != sclk_d) |-> (gap_q == GAP_W'(HALF_DIV)));

   // R3
   rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rises_q == RC_W'(FRAME_W)));

   // R7
   release_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_o && !cs_d) |-> done_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   hold_between_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(sample_o) && $stable(chan_o) && $stable(sub_o) && $stable(frame_err_o)));

   // R5
   unpack_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (sample_o == shadow_q[SUB_W +: RES_W] &&
                  chan_o == shadow_q[RES_W + SUB_W] &&
                  sub_o == shadow_q[SUB_W-1:0]));

   // R6
   marker_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (frame_err_o == ((CHECK_MARKER != 1'b0) &&
                  (shadow_q[FRAME_W-1 -: LEAD_W] != {LEAD_W{1'b1}}))));
endmodule

bind adc_rd_master adc_rd_master_chk #(
   .HALF_DIV(HALF_DIV), .LEAD_W(LEAD_W), .RES_W(RES_W), .SUB_W(SUB_W),
   .CHECK_MARKER(CHECK_MARKER)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .miso_i      (miso_i),
   .cs_n_o      (cs_n_o),
   .sclk_o      (sclk_o),
   .done_o      (done_o),
   .sample_o    (sample_o),
   .chan_o      (chan_o),
   .sub_o       (sub_o),
   .frame_err_o (frame_err_o)
);

// File: tb/adc_rd_master_tb_top.sv
`timescale 1ns/1ps
module adc_rd_master_tb_top;
   localparam int HALF_DIV = 47;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   wire  miso_w;
   logic cs_n_o, sclk_o, done_o, chan_o, frame_err_o;
   logic [9:0] sample_o;
   logic [1:0] sub_o;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   adc_rd_master dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .miso_i(miso_w),
      .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o), .sample_o(sample_o),
      .chan_o(chan_o), .sub_o(sub_o), .frame_err_o(frame_err_o)
   );

   // converter model: drives bit 15 at select, next bit at each falling edge
   logic [15:0] tx_word = 16'h0;
   int          bit_idx = 15;
   logic        prev_sclk = 1'b0;

   always @(cs_n_o or sclk_o) begin
      if (cs_n_o !== 1'b0) begin
         bit_idx = 15;
      end else if (sclk_o === 1'b0 && prev_sclk === 1'b1 && bit_idx > 0) begin
         bit_idx = bit_idx - 1;
      end
      prev_sclk = sclk_o;
   end

   assign miso_w = (cs_n_o === 1'b0) ? tx_word[bit_idx] : 1'bz;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [9:0] exp_sample(input logic [15:0] w);
      return w[11:2];
   endfunction
   function automatic logic exp_chan(input logic [15:0] w);
      return w[12];
   endfunction
   function automatic logic [1:0] exp_sub(input logic [15:0] w);
      return w[1:0];
   endfunction
   function automatic logic exp_err(input logic [15:0] w);
      return (w[15:13] != 3'b111);
   endfunction

   task automatic run_frame(input logic [15:0] w, input bit inject);
      int n = 0;
      int low = 0;
      int rises = 0;
      int first_rise = -1;
      int extra_done = 0;
      int cs_drops = 0;
      bit got = 0;
      logic prev = 1'b0;
      tx_word = w;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      check("R2", "select low after start", 32'(cs_n_o), 32'd0);
      check("R2", "clock low after start", 32'(sclk_o), 32'd0);
      while (!got && n < 5000) begin
         if (!cs_n_o) low++;
         if (sclk_o && !prev) begin
            rises++;
            if (first_rise < 0) first_rise = n;
         end
         prev = sclk_o;
         if (done_o) begin
            got = 1;
         end else begin
            @(negedge clk);
            n++;
            if (inject && n == 300) start_i = 1'b1;
            if (inject && n == 301) start_i = 1'b0;
         end
      end
      check("R8", "done seen", 32'(got), 32'd1);
      check("R2", "first rise delay", 32'(first_rise), 32'(HALF_DIV));
      check("R3", "rising edges", 32'(rises), 32'd16);
      check("R7", "select low cycles", 32'(low), 32'(32 * HALF_DIV));
      check("R7", "select high at done", 32'(cs_n_o), 32'd1);
      check("R7", "clock low at done", 32'(sclk_o), 32'd0);
      // R4 R5: bit order and field positions
      check("R5", "sample", 32'(sample_o), 32'(exp_sample(w)));
      check("R5", "channel", 32'(chan_o), 32'(exp_chan(w)));
      check("R5", "sub-bits", 32'(sub_o), 32'(exp_sub(w)));
      check("R6", "marker error", 32'(frame_err_o), 32'(exp_err(w)));
      for (int k = 0; k < 3 * HALF_DIV; k++) begin
         @(negedge clk);
         if (done_o) extra_done++;
         if (!cs_n_o) cs_drops++;
      end
      check(inject ? "R9" : "R8", "extra done pulses", 32'(extra_done), 32'd0);
      check(inject ? "R9" : "R8", "select stays high", 32'(cs_drops), 32'd0);
      check("R8", "sample held", 32'(sample_o), 32'(exp_sample(w)));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1
      check("R1", "select reset", 32'(cs_n_o), 32'd1);
      check("R1", "clock reset", 32'(sclk_o), 32'd0);
      check("R1", "done reset", 32'(done_o), 32'd0);
      check("R1", "outputs reset",
            32'({sample_o, chan_o, sub_o, frame_err_o}), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // directed corners (R4 order via asymmetric patterns, R6 marker cases)
      run_frame(16'hFFFF, 1'b0);
      run_frame(16'hE000, 1'b0);
      run_frame(16'hF556, 1'b0);
      run_frame(16'h0000, 1'b0);
      run_frame(16'h7ABD, 1'b0);
      run_frame(16'hB123, 1'b0);
      run_frame(16'hCF0E, 1'b0);
      // R9: start in mid-frame
      run_frame(16'hE9C1, 1'b1);

      void'($urandom(32'd20240611));
      for (int i = 0; i < 22; i++) begin
         logic [15:0] w;
         w = 16'($urandom);
         if ($urandom_range(3) != 0) w[15:13] = 3'b111;
         run_frame(w, ($urandom_range(4) == 0));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule